// File: doc/BRIEF.md
# Load-Use Interlock

This block sits between the fetch and execute stages of an in-order pipeline. It stops an instruction in decode from issuing while the instruction ahead of it, now in execute, is a memory read whose result the decode instruction needs.

When such a dependency is found, the block does three things in the same cycle:
- It freezes the program counter.
- It freezes the fetch/decode register.
- It loads an all-zero control word into the decode/execute register.

The frozen instructions repeat one cycle later, and the zero word travels down the pipeline as a no-operation slot. By then the load has moved on, and its result can be forwarded from the following stage.

The module holds the program counter, the fetch/decode register and the control half of the decode/execute register. Freezing and bubble insertion are therefore visible cycle by cycle at its ports. The fetched instruction enters already split into two source register numbers, one destination register number and a control word. Bit `RD_BIT` of the control word marks a memory read.

Top module: `load_use_interlock`

## Requirements
- R1: A stall is raised in a cycle exactly when the decode/execute control word has bit `RD_BIT` (default 0) set, its destination is nonzero, and that destination equals either source register number held in fetch/decode.
- R2: In a stall cycle `pc_write` is 0 and `pc` keeps its value across the next edge. Otherwise `pc_write` is 1 and `pc` advances by `PC_STEP` (default 4).
- R3: In a stall cycle `ifid_write` is 0 and all fetch/decode fields keep their values across the next edge. Otherwise they take the fetched fields.
- R4: In a stall cycle `bubble_sel` is 1 and the decode/execute control word becomes all zeros at the next edge.
- R5: A single load-use dependency costs exactly one stall cycle. A stall cycle is never followed directly by another.
- R6: Outside stalls, the control word entering decode/execute is the one held in fetch/decode. The stream of control words reaching execute is therefore the program order, with one zero word inserted per dependency.
- R7: A memory read whose destination is register 0 never causes a stall.
- R8: While reset is asserted, `pc` is `PC_RESET` (default 0), every fetch/decode field and the decode/execute control word are zero, and `pc_write` is 1.
- R9: An instruction whose control bit `RD_BIT` is clear never causes a stall, even when the next instruction reads its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fet_src_a | input | RW | First source register of the fetched instruction |
| fet_src_b | input | RW | Second source register of the fetched instruction |
| fet_dst | input | RW | Destination register of the fetched instruction |
| fet_ctrl | input | CW | Control word of the fetched instruction; bit RD_BIT marks a memory read |
| pc | output | PCW | Program counter |
| pc_write | output | 1 | 1 when the program counter advances |
| ifid_write | output | 1 | 1 when fetch/decode captures a new instruction |
| bubble_sel | output | 1 | 1 when a zero control word is sent to decode/execute |
| dec_src_a | output | RW | First source register held in fetch/decode |
| dec_src_b | output | RW | Second source register held in fetch/decode |
| dec_dst | output | RW | Destination register held in fetch/decode |
| dec_ctrl | output | CW | Control word held in fetch/decode |
| ex_dst | output | RW | Destination register held in decode/execute |
| ex_ctrl | output | CW | Control word held in decode/execute |

## Verification
The properties assume that the fetched fields are a pure function of `pc`, so a frozen counter presents the same instruction again. The bench keeps to this by serving each instruction from a small program table indexed by `pc`, with a fixed non-load filler past the end of the table.

The properties also assume that reset is released away from a clock edge. The bench always releases it on a falling edge.

Every program gives each instruction a distinct nonzero control word, so an all-zero word in execute can only be an inserted bubble. The programs cover these cases:
- a dependency through either source register;
- a load to register 0;
- a non-load producer;
- a dependency two instructions apart;
- a chain of loads that each feed the next.

// File: rtl/load_use_interlock.sv
module load_use_interlock #(
  parameter int RW       = 5,
  parameter int CW       = 8,
  parameter int PCW      = 32,
  parameter int PC_STEP  = 4,
  parameter int PC_RESET = 0,
  parameter int RD_BIT   = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RW-1:0]  fet_src_a,
  input  logic [RW-1:0]  fet_src_b,
  input  logic [RW-1:0]  fet_dst,
  input  logic [CW-1:0]  fet_ctrl,
  output logic [PCW-1:0] pc,
  output logic           pc_write,
  output logic           ifid_write,
  output logic           bubble_sel,
  output logic [RW-1:0]  dec_src_a,
  output logic [RW-1:0]  dec_src_b,
  output logic [RW-1:0]  dec_dst,
  output logic [CW-1:0]  dec_ctrl,
  output logic [RW-1:0]  ex_dst,
  output logic [CW-1:0]  ex_ctrl
);

  localparam logic [PCW-1:0] STEP  = PCW'(PC_STEP);
  localparam logic [PCW-1:0] START = PCW'(PC_RESET);

  logic ex_reads, dst_live, src_hit, stall;

  assign ex_reads   = ex_ctrl[RD_BIT];
  assign dst_live   = (ex_dst != '0);
  assign src_hit    = (ex_dst == dec_src_a) || (ex_dst == dec_src_b);
  assign stall      = ex_reads && dst_live && src_hit;

  assign pc_write   = !stall;
  assign ifid_write = !stall;
  assign bubble_sel = stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= START;
    end else if (pc_write) begin
      pc <= pc + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_src_a <= '0;
      dec_src_b <= '0;
      dec_dst   <= '0;
      dec_ctrl  <= '0;
    end else if (ifid_write) begin
      dec_src_a <= fet_src_a;
      dec_src_b <= fet_src_b;
      dec_dst   <= fet_dst;
      dec_ctrl  <= fet_ctrl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_dst  <= '0;
      ex_ctrl <= '0;
    end else begin
      ex_dst  <= dec_dst;
      ex_ctrl <= bubble_sel ? '0 : dec_ctrl;
    end
  end

  p_freeze_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_write |=> $stable(pc));
  p_step_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_write |=> pc == $past(pc) + STEP);
  p_freeze_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ifid_write |=> $stable({dec_src_a, dec_src_b, dec_dst, dec_ctrl}));
  p_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |=> ex_ctrl == '0);
  p_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |=> !bubble_sel);
  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bubble_sel |=> ex_ctrl == $past(dec_ctrl));
  p_zero_dst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0) |-> pc_write);
  p_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_ctrl[RD_BIT] |-> ifid_write);

endmodule

// File: tb/load_use_interlock_tb.sv
`timescale 1ns/1ps
module load_use_interlock_tb;
  localparam int RW = 5, CW = 8, PCW = 32;

  logic clk = 0, rst_n = 0;
  logic [RW-1:0] fet_src_a, fet_src_b, fet_dst;
  logic [CW-1:0] fet_ctrl;
  logic [PCW-1:0] pc;
  logic pc_write, ifid_write, bubble_sel;
  logic [RW-1:0] dec_src_a, dec_src_b, dec_dst, ex_dst;
  logic [CW-1:0] dec_ctrl, ex_ctrl;

  int checks = 0, errors = 0;
  int plen = 0;
  logic [RW-1:0] p_a [16];
  logic [RW-1:0] p_b [16];
  logic [RW-1:0] p_d [16];
  logic [CW-1:0] p_c [16];

  always #10 clk = ~clk;

  load_use_interlock u_dut (
    .clk(clk), .rst_n(rst_n),
    .fet_src_a(fet_src_a), .fet_src_b(fet_src_b), .fet_dst(fet_dst), .fet_ctrl(fet_ctrl),
    .pc(pc), .pc_write(pc_write), .ifid_write(ifid_write), .bubble_sel(bubble_sel),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst(dec_dst), .dec_ctrl(dec_ctrl),
    .ex_dst(ex_dst), .ex_ctrl(ex_ctrl)
  );

  always_comb begin
    if ((pc >> 2) < PCW'(plen)) begin
      fet_src_a = p_a[pc[5:2]];
      fet_src_b = p_b[pc[5:2]];
      fet_dst   = p_d[pc[5:2]];
      fet_ctrl  = p_c[pc[5:2]];
    end else begin
      fet_src_a = '0;
      fet_src_b = '0;
      fet_dst   = '0;
      fet_ctrl  = 8'h80;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic set_ins(input int i, input int a, input int b, input int d, input bit ld);
    p_a[i] = RW'(a);
    p_b[i] = RW'(b);
    p_d[i] = RW'(d);
    p_c[i] = CW'(((i + 1) << 1) | int'(ld));
  endtask

  function automatic bit dep(input int i, input int j);
    return p_c[i][0] && (p_d[i] != 0) && (p_d[i] == p_a[j] || p_d[i] == p_b[j]);
  endfunction

  task automatic run_case(input string name, input int n, input string req);
    logic [CW-1:0] expq [40];
    int en = 0, nst = 0, seen = 0;
    logic [PCW-1:0] ppc;
    logic pw;
    logic [RW-1:0] pa, pb, pd;
    logic [CW-1:0] pcw;
    plen = n;
    expq[en++] = '0;
    for (int j = 0; j < n; j++) begin
      if (j > 0 && dep(j - 1, j)) begin
        expq[en++] = '0;
        nst++;
      end
      expq[en++] = p_c[j];
    end
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    ppc = pc; pw = pc_write; pa = dec_src_a; pb = dec_src_b; pd = dec_dst; pcw = dec_ctrl;
    for (int k = 1; k <= en + 2; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k <= en)
        chk(ex_ctrl == expq[k-1], "R6", {name, " execute control stream"}, ex_ctrl, expq[k-1]);
      if (!pw) begin
        seen++;
        chk(pc == ppc, "R2", {name, " pc frozen"}, pc, ppc);
        chk({dec_src_a, dec_src_b, dec_dst, dec_ctrl} == {pa, pb, pd, pcw}, "R3",
            {name, " decode frozen"}, dec_ctrl, pcw);
        chk(ex_ctrl == '0, "R4", {name, " bubble after stall"}, ex_ctrl, 0);
        chk(pc_write == 1'b1, "R5", {name, " stall lasts one cycle"}, pc_write, 1);
      end else begin
        chk(pc == ppc + 4, "R2", {name, " pc advance"}, pc, ppc + 4);
      end
      chk(ifid_write == pc_write && bubble_sel == !pc_write, "R4",
          {name, " control agreement"}, bubble_sel, !pc_write);
      ppc = pc; pw = pc_write; pa = dec_src_a; pb = dec_src_b; pd = dec_dst; pcw = dec_ctrl;
    end
    chk(seen == nst, req, {name, " stall count"}, seen, nst);
  endtask

  task automatic t_reset();
    rst_n = 0;
    plen = 0;
    @(negedge clk);
    chk(pc == 0, "R8", "reset pc", pc, 0);
    chk({dec_src_a, dec_src_b, dec_dst, dec_ctrl} == '0, "R8", "reset decode", dec_ctrl, 0);
    chk(ex_ctrl == '0, "R8", "reset execute ctrl", ex_ctrl, 0);
    chk(pc_write == 1'b1, "R8", "reset pc_write", pc_write, 1);
  endtask

  task automatic t_use_a();
    set_ins(0, 3, 4, 5, 1);
    set_ins(1, 5, 6, 7, 0);
    set_ins(2, 1, 2, 8, 0);
    run_case("use_src_a", 3, "R1");
  endtask

  task automatic t_use_b();
    set_ins(0, 3, 4, 9, 1);
    set_ins(1, 2, 9, 7, 0);
    set_ins(2, 9, 9, 8, 0);
    run_case("use_src_b", 3, "R5");
  endtask

  task automatic t_zero_dst();
    set_ins(0, 3, 4, 0, 1);
    set_ins(1, 0, 0, 7, 0);
    run_case("zero_dst", 2, "R7");
  endtask

  task automatic t_not_load();
    set_ins(0, 3, 4, 5, 0);
    set_ins(1, 5, 5, 7, 0);
    run_case("non_load", 2, "R9");
  endtask

  task automatic t_distance();
    set_ins(0, 3, 4, 5, 1);
    set_ins(1, 1, 2, 6, 0);
    set_ins(2, 5, 6, 7, 0);
    run_case("distance_two", 3, "R1");
  endtask

  task automatic t_chain();
    set_ins(0, 3, 4, 1, 1);
    set_ins(1, 1, 4, 2, 1);
    set_ins(2, 6, 2, 3, 1);
    set_ins(3, 3, 3, 4, 0);
    set_ins(4, 7, 7, 8, 0);
    run_case("load_chain", 5, "R6");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R5: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_use_a();
    t_use_b();
    t_zero_dst();
    t_not_load();
    t_distance();
    t_chain();
    finish_run();
  end
endmodule